// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns parallel characters into an asynchronous serial stream on a single line that idles high. Each character is framed by a low start bit and a high stop bit. Its data bits go out least significant first, and the character is 8 or 9 bits long. A separate input supplies the ninth bit. Parity can optionally take the place of the most significant data bit. The block advances one bit time for each pulse on a bit-rate enable input that comes from an external divider. A single holding buffer sits in front of the shift stage, so a new character can be loaded while the previous one is still on the line. Characters then follow each other with no idle bits between them.

The block can also send two special characters. When the transmitter is switched on, it first sends an idle preamble: one character time of ones with no start bit. A send-break control puts out break characters, which are all zeros for the whole character time. A short pulse on this control produces exactly one break followed by a single one bit, so that the receiver can find the next start bit. Holding the control high produces breaks back to back with no gaps. When a break and a preamble are both waiting at a character boundary, the break wins and the preamble is dropped.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, and no break and no preamble are pending. A break request captured just before reset produces no zero bits afterwards.
- R2: A data character is sent as `txd` = 0 (start bit), then N data bits least significant first, then 1 (stop bit). N is 8 when `nine_bit` = 0 and 9 when `nine_bit` = 1, in which case `din8` is the last data bit. Each `bit_tick` pulse moves `txd` on by exactly one bit.
- R3: When `par_en` = 1, the last data bit position carries parity instead of data. That is bit index 7 with `nine_bit` = 0 and bit index 8 with `nine_bit` = 1. The parity covers the data bits below that position: even parity when `par_odd` = 0, odd parity when `par_odd` = 1.
- R4: A word is accepted when `din_valid` = 1 and `tx_empty` = 1, and `tx_empty` then goes to 0. `tx_empty` returns to 1 on the tick that sends that character's start bit. A word loaded before the stop bit goes out immediately after it, with no idle bit in between.
- R5: A rising edge on `tx_en` queues a preamble of L = N+2 bit times of 1 with no start bit. The preamble goes out before any waiting data character.
- R6: A one-cycle pulse on `brk_req` sends exactly one break (L bits of 0). It is followed by exactly one 1 bit. Only after that 1 bit does a waiting data character start.
- R7: While `brk_req` stays at 1, break characters follow each other with no 1 bits between them. After `brk_req` falls, one 1 bit ends the last break.
- R8: If a break request arrives before a queued preamble has started, the break is sent and the preamble is discarded.
- R9: While `tx_en` = 0, no character starts, `txd` stays 1, and a loaded word stays in the buffer.
- R10: `tx_done` = 1 exactly when no character, preamble, break or trailing 1 bit is on the line, the buffer is empty, and no break or preamble is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable; a rising edge queues a preamble |
| brk_req | input | 1 | Send-break control |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Parity replaces the last data bit |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| din | input | 8 | Low data bits of the word to send |
| din8 | input | 1 | Ninth data bit |
| din_valid | input | 1 | Load request for `din`/`din8` |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding buffer empty; load accepted when high |
| tx_done | output | 1 | Line and buffer idle, nothing pending |

## Verification
Three things can fall on the same character boundary: a break request, a queued preamble and a buffered data word. The bench provokes this in two ways. In one case it raises `tx_en` and pulses `brk_req` in the same idle stretch before any tick. In the other it loads a word while a break is already running. The first case passes only if `txd` shows L zeros and one 1, and `tx_done` comes back one tick later, which shows that no preamble was sent. The second case passes only if the data frame starts on the tick right after the single 1 bit, and `tx_empty` stays low until then.

// File: rtl/txb_pkg.sv
package txb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BRK,
        ST_DATA,
        ST_MARK
    } seq_st_t;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } fmt_t;

    function automatic logic par_fill(input logic folded, input logic odd);
        return folded ^ odd;
    endfunction

endpackage

// File: rtl/txb_hold.sv
module txb_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              din8,
    input  logic              din_valid,
    input  logic              take,
    output logic              full,
    output logic [DATA_W:0]   word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (din_valid && !full) begin
            full <= 1'b1;
            word <= {din8, din};
        end
    end

    // R4: a held word stays put until the sequencer takes it
    a_r4_hold_word: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(word)));

endmodule

// File: rtl/txb_req.sv
module txb_req (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic brk_req,
    input  logic start_brk,
    input  logic start_pre,
    output logic brk_pend,
    output logic pre_pend
);

    logic en_q;
    logic brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            brk_q    <= 1'b0;
            brk_pend <= 1'b0;
            pre_pend <= 1'b0;
        end else begin
            en_q  <= tx_en;
            brk_q <= brk_req;
            if (!tx_en || start_brk)
                brk_pend <= 1'b0;
            else if (brk_req && !brk_q)
                brk_pend <= 1'b1;
            if (!tx_en || start_pre || start_brk)
                pre_pend <= 1'b0;
            else if (!en_q)
                pre_pend <= 1'b1;
        end
    end

    // R8: once a break starts, no preamble remains queued
    a_r8_pre_dropped: assert property (@(posedge clk) disable iff (rst)
        start_brk |=> !pre_pend);

endmodule

// File: rtl/txb_seq.sv
module txb_seq
    import txb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_tick,
    input  logic            tx_en,
    input  logic            brk_req,
    input  logic            brk_pend,
    input  logic            pre_pend,
    input  logic            buf_full,
    input  logic [DATA_W:0] word,
    input  fmt_t            fmt,
    output logic            txd,
    output logic            take,
    output logic            start_brk,
    output logic            start_pre,
    output logic            idle
);

    localparam int SH_W  = DATA_W + 2;
    localparam int CNT_W = $clog2(DATA_W + 3);

    seq_st_t          st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n, last_idx;
    logic [SH_W-1:0]  sh, sh_n;
    logic             txd_n;
    logic             boundary, brk_want, mark_now, pbit;
    logic [DATA_W:0]  pmask, dbits;

    // character image: data bits, then ninth bit or stop, filler ones above
    always_comb begin
        pmask = fmt.nine ? {1'b0, {DATA_W{1'b1}}} : {2'b00, {(DATA_W-1){1'b1}}};
        pbit  = par_fill(^(word & pmask), fmt.par_odd);
        dbits = word;
        if (!fmt.nine)
            dbits[DATA_W] = 1'b1;
        if (fmt.par_en) begin
            if (fmt.nine)
                dbits[DATA_W] = pbit;
            else
                dbits[DATA_W-1] = pbit;
        end
        last_idx = CNT_W'(DATA_W + 1) + CNT_W'(fmt.nine);
    end

    always_comb begin
        boundary  = bit_tick && (st == ST_IDLE || cnt == '0);
        brk_want  = brk_req || brk_pend;
        mark_now  = boundary && st == ST_BRK && !brk_want;
        start_brk = boundary && tx_en && brk_want;
        start_pre = boundary && !mark_now && tx_en && !brk_want && pre_pend;
        take      = boundary && !mark_now && tx_en && !brk_want && !pre_pend && buf_full;

        st_n  = st;
        cnt_n = cnt;
        sh_n  = sh;
        txd_n = txd;
        if (boundary) begin
            if (mark_now) begin
                st_n  = ST_MARK;
                cnt_n = '0;
                txd_n = 1'b1;
            end else if (start_brk) begin
                st_n  = ST_BRK;
                cnt_n = last_idx;
                txd_n = 1'b0;
            end else if (start_pre) begin
                st_n  = ST_PRE;
                cnt_n = last_idx;
                txd_n = 1'b1;
            end else if (take) begin
                st_n  = ST_DATA;
                cnt_n = last_idx;
                sh_n  = {1'b1, dbits};
                txd_n = 1'b0;
            end else begin
                st_n  = ST_IDLE;
                cnt_n = '0;
                txd_n = 1'b1;
            end
        end else if (bit_tick) begin
            cnt_n = cnt - CNT_W'(1);
            sh_n  = {1'b1, sh[SH_W-1:1]};
            case (st)
                ST_DATA: txd_n = sh[0];
                ST_BRK:  txd_n = 1'b0;
                default: txd_n = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            sh  <= '1;
            txd <= 1'b1;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            sh  <= sh_n;
            txd <= txd_n;
        end
    end

    assign idle = (st == ST_IDLE);

    // R2: line high whenever nothing is being sent
    a_r2_idle_line: assert property (@(posedge clk) disable iff (rst)
        idle |-> txd);

    // R2: the line only moves on a bit tick
    a_r2_tick_paced: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(cnt) && $stable(txd)));

    // R6: the trailing one lasts a single bit time
    a_r6_single_mark: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MARK && bit_tick) |=> (st != ST_MARK));

    // R7: held request chains breaks with the line kept low
    a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
        (boundary && st == ST_BRK && brk_req && tx_en) |=> (st == ST_BRK && !txd));

    // R9: a disabled idle transmitter starts nothing
    a_r9_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (idle && !tx_en) |=> idle);

endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk
    import txb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] din,
    input  logic              din8,
    input  logic              din_valid,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done
);

    fmt_t            fmt;
    logic            take, start_brk, start_pre, idle;
    logic            brk_pend, pre_pend, buf_full;
    logic [DATA_W:0] word;

    always_comb begin
        fmt.nine    = nine_bit;
        fmt.par_en  = par_en;
        fmt.par_odd = par_odd;
    end

    txb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .din8      (din8),
        .din_valid (din_valid),
        .take      (take),
        .full      (buf_full),
        .word      (word)
    );

    txb_req u_req (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .start_brk (start_brk),
        .start_pre (start_pre),
        .brk_pend  (brk_pend),
        .pre_pend  (pre_pend)
    );

    txb_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .brk_pend  (brk_pend),
        .pre_pend  (pre_pend),
        .buf_full  (buf_full),
        .word      (word),
        .fmt       (fmt),
        .txd       (txd),
        .take      (take),
        .start_brk (start_brk),
        .start_pre (start_pre),
        .idle      (idle)
    );

    assign tx_empty = !buf_full;
    assign tx_done  = idle && !buf_full && !pre_pend && !brk_pend && !(tx_en && brk_req);

    // R10: a pending preamble keeps the complete flag low
    a_r10_pre_busy: assert property (@(posedge clk) disable iff (rst)
        pre_pend |-> !tx_done);

endmodule

// File: tb/tb_serial_tx_brk.sv
`timescale 1ns/1ps
module tb_serial_tx_brk;

    logic       clk = 1'b0;
    logic       rst, bit_tick, tx_en, brk_req, nine_bit, par_en, par_odd;
    logic [7:0] din;
    logic       din8, din_valid;
    logic       txd, tx_empty, tx_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    serial_tx_brk dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en), .brk_req(brk_req),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd), .din(din), .din8(din8),
        .din_valid(din_valid), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(output logic b);
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        b = txd;
    endtask

    task automatic load(input logic [8:0] v);
        @(negedge clk);
        din = v[7:0]; din8 = v[8]; din_valid = 1'b1;
        @(negedge clk) din_valid = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) brk_req = 1'b0;
    endtask

    function automatic logic [11:0] exp_frame(input int v, input bit nine, input bit pe, input bit po);
        logic [11:0] f;
        int n, ones;
        f = '1;
        n = nine ? 9 : 8;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) f[i+1] = v[i];
        if (pe) begin
            ones = 0;
            for (int i = 0; i < n - 1; i++) ones += v[i];
            f[n] = ones[0] ^ po;
        end
        f[n+1] = 1'b1;
        return f;
    endfunction

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic        b, flag;
        logic [11:0] cap;
        logic [31:0] cap32, exp32;
        logic [11:0] ef;

        rst = 1'b1; bit_tick = 1'b0; tx_en = 1'b0; brk_req = 1'b0;
        nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        din = '0; din8 = 1'b0; din_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R10 reset state
        chk("R1 line idle after reset", txd, 1);
        chk("R1 buffer empty after reset", tx_empty, 1);
        chk("R10 complete after reset", tx_done, 1);

        // R9 disabled: word held, line high
        load(9'h0A5);
        chk("R9 word accepted while disabled", tx_empty, 0);
        flag = 1'b1;
        for (int k = 0; k < 20; k++) begin tick(b); if (!b) flag = 1'b0; end
        chk("R9 line high while disabled", flag, 1);
        chk("R9 word retained while disabled", tx_empty, 0);

        // R5 preamble on enable, data waits behind it
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
        chk("R10 busy while preamble queued", tx_done, 0);
        flag = 1'b1;
        for (int k = 0; k < 10; k++) begin tick(b); if (!b) flag = 1'b0; end
        chk("R5 preamble is ten ones", flag, 1);
        chk("R5 data waits behind preamble", tx_empty, 0);
        cap = '1;
        for (int k = 0; k < 10; k++) begin tick(b); cap[k] = b; end
        chk("R5 frame right after preamble", cap, exp_frame(32'h0A5, 0, 0, 0));
        tick(b);
        chk("R10 complete once drained", tx_done, 1);

        // R2 / R3 / R4 exhaustive back-to-back sweep
        for (int m = 0; m < 8; m++) begin
            int nmax, len;
            if (m[1] == 1'b0 && m[0] == 1'b1) continue;
            @(negedge clk);
            nine_bit = m[2]; par_en = m[1]; par_odd = m[0];
            nmax = m[2] ? 512 : 256;
            len  = m[2] ? 11 : 10;
            load(9'd0);
            for (int v = 0; v < nmax; v++) begin
                cap = '1;
                tick(b);
                cap[0] = b;
                if (v == 0 || v == nmax - 1)
                    chk("R4 buffer freed at start bit", tx_empty, 1);
                if (v + 1 < nmax) load(9'(v + 1));
                for (int k = 1; k < len; k++) begin tick(b); cap[k] = b; end
                ef = exp_frame(v, m[2], m[1], m[0]);
                if (m[1])
                    chk($sformatf("R3 parity frame v=%0d mode=%0d", v, m), cap, ef);
                else
                    chk($sformatf("R2 frame v=%0d mode=%0d", v, m), cap, ef);
            end
            tick(b);
            chk("R10 complete after stream", tx_done, 1);
        end

        // R6 single break, one mark, then queued data
        @(negedge clk);
        nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        pulse_brk();
        load(9'h03C);
        cap32 = '1;
        for (int k = 0; k < 21; k++) begin
            tick(b);
            cap32[k] = b;
            if (k == 10) chk("R6 data held until after mark", tx_empty, 0);
        end
        ef = exp_frame(32'h03C, 0, 0, 0);
        exp32 = '1;
        exp32[9:0] = '0;
        exp32[10] = 1'b1;
        exp32[20:11] = ef[9:0];
        chk("R6 break, one mark, then frame", cap32, exp32);
        tick(b);
        chk("R10 complete after break and frame", tx_done, 1);

        // R7 held break
        @(negedge clk) brk_req = 1'b1;
        flag = 1'b1;
        for (int k = 0; k < 30; k++) begin tick(b); if (b) flag = 1'b0; end
        chk("R7 thirty zero bits while held", flag, 1);
        chk("R10 busy during break", tx_done, 0);
        @(negedge clk) brk_req = 1'b0;
        tick(b);
        chk("R7 one after release", b, 1);
        chk("R10 busy during trailing one", tx_done, 0);
        tick(b);
        chk("R7 idle after single mark", tx_done, 1);

        // R8 break requested before the preamble begins
        @(negedge clk) tx_en = 1'b0;
        tick(b);
        tick(b);
        @(negedge clk);
        tx_en = 1'b1; brk_req = 1'b1;
        @(negedge clk) brk_req = 1'b0;
        flag = 1'b1;
        for (int k = 0; k < 10; k++) begin tick(b); if (b) flag = 1'b0; end
        chk("R8 break replaces preamble", flag, 1);
        tick(b);
        chk("R8 mark after replacing break", b, 1);
        chk("R10 busy during mark", tx_done, 0);
        tick(b);
        chk("R8 no preamble after break", tx_done, 1);

        // R1 reset discards a captured break request
        pulse_brk();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        flag = 1'b1;
        for (int k = 0; k < 10; k++) begin tick(b); if (!b) flag = 1'b0; end
        chk("R1 no break after reset", flag, 1);
        tick(b);
        chk("R1 idle after post-reset preamble", tx_done, 1);

        finish_up();
    end

endmodule